// File: doc/BRIEF.md
# Ethernet Receive Frame Queue

This block buffers received Ethernet frames between a MAC receive port and a DMA-style reader. The MAC hands over 32-bit beats marked with start-of-frame, end-of-frame and a 4-bit byte enable. After the last beat it hands over a status word, and it may also supply a 64-bit timestamp with it. All of these go into one shared queue in arrival order. Each entry carries a 2-bit type tag, so the reader can tell frame data, timestamp halves and status apart without a second channel.

A configuration input selects how readiness is reported. In cut-through mode a frame's words become readable as soon as they are stored. The reader is prompted once enough bytes are buffered or a whole frame has arrived. In store-and-forward mode a frame stays hidden until its status is stored. A frame whose status reports an error, or which lost beats to a full queue, is removed by moving the write pointer back to where that frame began.

The MAC is never stalled. A status word follows end-of-frame by at least one cycle. The next start-of-frame follows a status word by at least three cycles. The mode inputs are changed only while the queue is empty.

Top module: `rx_frame_queue`

## Requirements
- R1: Each accepted MAC beat is stored as one entry with tag 0 (data) and comes out of the read port in arrival order. The entry keeps its word, start-of-frame flag, end-of-frame flag and byte enables.
- R2: A frame's status word is stored with tag 3, after all of that frame's data entries and after any timestamp entries.
- R3: When `cfg_ts_en` is high and `mac_ts_valid` is high in the status cycle, two entries come before the status. The first has tag 1 and holds timestamp bits 31:0; the second has tag 2 and holds bits 63:32. Otherwise no timestamp entries are stored.
- R4: In cut-through mode, `rd_avail` is high when either of these is true: at least `THRESH_BYTES`/4 words (16 by default) are buffered, or at least one complete frame including its status is buffered.
- R5: In cut-through mode, `rd_valid` is high whenever any entry is stored. A frame whose status has the error bit (bit 15) set is still delivered in full, with its status unchanged.
- R6: In store-and-forward mode, no entry of a frame is readable (`rd_valid` and `rd_avail` stay low) until that frame's status entry has been stored.
- R7: In store-and-forward mode, a frame with status bit 15 set, or with a dropped beat, leaves nothing in the queue. Frames before and after it are delivered intact.
- R8: Several complete frames may be held at once. `rd_avail` stays high until the status entry of the last buffered frame has been read.
- R9: A data beat is stored only while fewer than DEPTH-3 entries are occupied. After one beat of a frame is refused, the rest of that frame's beats are dropped. In cut-through mode, that frame's stored status then has bit 14 set. The next frame starts with the flag clear.
- R10: After reset, `rd_valid` and `rd_avail` are low. A read request made while `rd_valid` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_store_fwd | input | 1 | 1 = store-and-forward, 0 = cut-through |
| cfg_ts_en | input | 1 | Enables storing of timestamps |
| mac_valid | input | 1 | Data beat present |
| mac_data | input | 32 | Data beat word |
| mac_sof | input | 1 | Beat is first of a frame |
| mac_eof | input | 1 | Beat is last of a frame |
| mac_be | input | 4 | Byte enables of the beat |
| mac_stat_valid | input | 1 | Status word present |
| mac_stat | input | 32 | Frame status (bit 15 = error) |
| mac_ts_valid | input | 1 | Timestamp accompanies status |
| mac_ts | input | 64 | Frame timestamp |
| rd_en | input | 1 | Pop the head entry |
| rd_valid | output | 1 | Head entry is readable |
| rd_avail | output | 1 | Reader should start transferring |
| rd_data | output | 32 | Head entry word |
| rd_tag | output | 2 | Head entry type: 0 data, 1 ts low, 2 ts high, 3 status |
| rd_sof | output | 1 | Head entry start-of-frame |
| rd_eof | output | 1 | Head entry end-of-frame |
| rd_be | output | 4 | Head entry byte enables |

## Verification
A data beat sampled at a clock edge is visible at the read port, and counted towards `rd_avail`, right after that same edge. A timestamped status produces its three entries at that edge and the next two. A completed frame raises `rd_avail` at the edge where its status entry is written. The bench drives every input at a falling edge and samples at the next falling edge or later. After a status, it waits three idle cycles before any check, so that every trailer entry is in place when the check runs. Pops are one per cycle, so each expected head entry is compared at the falling edge after the previous pop.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   localparam int WORD_W = 32;

   typedef enum logic [1:0] {
      TAG_DATA  = 2'd0,
      TAG_TS_LO = 2'd1,
      TAG_TS_HI = 2'd2,
      TAG_STAT  = 2'd3
   } rxq_tag_e;

   typedef struct packed {
      rxq_tag_e          tag;
      logic              sof;
      logic              eof;
      logic [3:0]        be;
      logic [WORD_W-1:0] word;
   } rxq_entry_t;
endpackage

// File: rtl/rxq_wr_ctrl.sv
module rxq_wr_ctrl
   import rxq_pkg::*;
#(
   parameter int ERR_BIT = 15,
   parameter int OVF_BIT = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_store_fwd,
   input  logic              cfg_ts_en,
   input  logic              mac_valid,
   input  logic [WORD_W-1:0] mac_data,
   input  logic              mac_sof,
   input  logic              mac_eof,
   input  logic [3:0]        mac_be,
   input  logic              mac_stat_valid,
   input  logic [WORD_W-1:0] mac_stat,
   input  logic              mac_ts_valid,
   input  logic [63:0]       mac_ts,
   input  logic              room,
   output logic              push,
   output rxq_entry_t        entry,
   output logic              commit,
   output logic              rewind
);
   logic [1:0]        pend_q;
   logic              ovf_q;
   logic [WORD_W-1:0] ts_hi_q;
   logic [WORD_W-1:0] stat_q;
   logic [WORD_W-1:0] stat_word;
   logic              bad;
   logic              accept;
   logic              start_ts;

   always_comb begin
      push      = 1'b0;
      entry     = '0;
      commit    = 1'b0;
      rewind    = 1'b0;
      accept    = 1'b0;
      start_ts  = 1'b0;
      stat_word = mac_stat | (WORD_W'(ovf_q) << OVF_BIT);
      bad       = mac_stat[ERR_BIT] | ovf_q;
      if (pend_q == 2'd2) begin
         push       = 1'b1;
         entry.tag  = TAG_TS_HI;
         entry.word = ts_hi_q;
      end else if (pend_q == 2'd1) begin
         push       = 1'b1;
         entry.tag  = TAG_STAT;
         entry.word = stat_q;
         commit     = 1'b1;
      end else if (mac_stat_valid) begin
         if (cfg_store_fwd && bad) begin
            rewind = 1'b1;
         end else if (cfg_ts_en && mac_ts_valid) begin
            push       = 1'b1;
            start_ts   = 1'b1;
            entry.tag  = TAG_TS_LO;
            entry.word = mac_ts[31:0];
         end else begin
            push       = 1'b1;
            entry.tag  = TAG_STAT;
            entry.word = stat_word;
            commit     = 1'b1;
         end
      end else if (mac_valid && room && !ovf_q) begin
         accept     = 1'b1;
         push       = 1'b1;
         entry.tag  = TAG_DATA;
         entry.sof  = mac_sof;
         entry.eof  = mac_eof;
         entry.be   = mac_be;
         entry.word = mac_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q  <= 2'd0;
         ovf_q   <= 1'b0;
         ts_hi_q <= '0;
         stat_q  <= '0;
      end else begin
         if (pend_q != 2'd0) begin
            pend_q <= pend_q - 2'd1;
         end else if (start_ts) begin
            pend_q  <= 2'd2;
            ts_hi_q <= mac_ts[63:32];
            stat_q  <= stat_word;
         end
         if (pend_q == 2'd0) begin
            if (mac_stat_valid)
               ovf_q <= 1'b0;
            else if (mac_valid && !accept)
               ovf_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/rxq_store.sv
module rxq_store
   import rxq_pkg::*;
#(
   parameter int DEPTH   = 512,
   parameter int RESERVE = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  rxq_entry_t                 wr_entry,
   input  logic                       commit,
   input  logic                       rewind,
   input  logic                       show_all,
   input  logic                       pop,
   output rxq_entry_t                 rd_entry,
   output logic [$clog2(DEPTH):0]     used,
   output logic [$clog2(DEPTH):0]     vis_cnt,
   output logic                       room
);
   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;

   rxq_entry_t    mem [DEPTH];
   logic [PW-1:0] wr_q;
   logic [PW-1:0] rd_q;
   logic [PW-1:0] cm_q;

   always_ff @(posedge clk) begin
      if (push)
         mem[wr_q[AW-1:0]] <= wr_entry;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q <= '0;
         rd_q <= '0;
         cm_q <= '0;
      end else begin
         if (rewind)
            wr_q <= cm_q;
         else if (push)
            wr_q <= wr_q + PW'(1);
         if (commit)
            cm_q <= wr_q + PW'(1);
         if (pop)
            rd_q <= rd_q + PW'(1);
      end
   end

   always_comb begin
      used     = wr_q - rd_q;
      vis_cnt  = (show_all ? wr_q : cm_q) - rd_q;
      room     = used < PW'(DEPTH - RESERVE);
      rd_entry = mem[rd_q[AW-1:0]];
   end
endmodule

// File: rtl/rxq_avail.sv
module rxq_avail #(
   parameter int DEPTH        = 512,
   parameter int THRESH_WORDS = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   store_fwd,
   input  logic                   commit,
   input  logic                   pop_stat,
   input  logic [$clog2(DEPTH):0] vis_cnt,
   output logic                   avail
);
   localparam int PW = $clog2(DEPTH) + 1;

   logic [PW-1:0] frames_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         frames_q <= '0;
      else if (commit && !pop_stat)
         frames_q <= frames_q + PW'(1);
      else if (pop_stat && !commit)
         frames_q <= frames_q - PW'(1);
   end

   generate
      if (THRESH_WORDS == 0) begin : g_frame_only
         logic unused_in;
         assign unused_in = store_fwd ^ (^vis_cnt);
         assign avail     = frames_q != '0;
      end else begin : g_thresh
         assign avail = (frames_q != '0) ||
                        (!store_fwd && (vis_cnt >= PW'(THRESH_WORDS)));
      end
   endgenerate
endmodule

// File: rtl/rx_frame_queue.sv
module rx_frame_queue
   import rxq_pkg::*;
#(
   parameter int DEPTH        = 512,
   parameter int THRESH_BYTES = 64,
   parameter int ERR_BIT      = 15,
   parameter int OVF_BIT      = 14
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_store_fwd,
   input  logic        cfg_ts_en,
   input  logic        mac_valid,
   input  logic [31:0] mac_data,
   input  logic        mac_sof,
   input  logic        mac_eof,
   input  logic [3:0]  mac_be,
   input  logic        mac_stat_valid,
   input  logic [31:0] mac_stat,
   input  logic        mac_ts_valid,
   input  logic [63:0] mac_ts,
   input  logic        rd_en,
   output logic        rd_valid,
   output logic        rd_avail,
   output logic [31:0] rd_data,
   output logic [1:0]  rd_tag,
   output logic        rd_sof,
   output logic        rd_eof,
   output logic [3:0]  rd_be
);
   localparam int PW           = $clog2(DEPTH) + 1;
   localparam int RESERVE      = 3;
   localparam int THRESH_WORDS = THRESH_BYTES / 4;

   generate
      if ((1 << (PW - 1)) != DEPTH || DEPTH < 8)
         $error("DEPTH must be a power of two, at least 8");
      if (THRESH_WORDS >= DEPTH - RESERVE)
         $error("THRESH_BYTES too large for DEPTH");
      if (ERR_BIT == OVF_BIT || ERR_BIT > 31 || OVF_BIT > 31)
         $error("ERR_BIT and OVF_BIT must be distinct bits of the status");
   endgenerate

   rxq_entry_t    wr_entry;
   rxq_entry_t    rd_entry;
   logic          wr_push;
   logic          wr_commit;
   logic          wr_rewind;
   logic          room;
   logic          pop;
   logic [PW-1:0] used_cnt;
   logic [PW-1:0] vis_cnt;

   rxq_wr_ctrl #(
      .ERR_BIT (ERR_BIT),
      .OVF_BIT (OVF_BIT)
   ) u_wr (
      .clk            (clk),
      .rst_n          (rst_n),
      .cfg_store_fwd  (cfg_store_fwd),
      .cfg_ts_en      (cfg_ts_en),
      .mac_valid      (mac_valid),
      .mac_data       (mac_data),
      .mac_sof        (mac_sof),
      .mac_eof        (mac_eof),
      .mac_be         (mac_be),
      .mac_stat_valid (mac_stat_valid),
      .mac_stat       (mac_stat),
      .mac_ts_valid   (mac_ts_valid),
      .mac_ts         (mac_ts),
      .room           (room),
      .push           (wr_push),
      .entry          (wr_entry),
      .commit         (wr_commit),
      .rewind         (wr_rewind)
   );

   rxq_store #(
      .DEPTH   (DEPTH),
      .RESERVE (RESERVE)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (wr_push),
      .wr_entry (wr_entry),
      .commit   (wr_commit),
      .rewind   (wr_rewind),
      .show_all (!cfg_store_fwd),
      .pop      (pop),
      .rd_entry (rd_entry),
      .used     (used_cnt),
      .vis_cnt  (vis_cnt),
      .room     (room)
   );

   assign rd_valid = vis_cnt != '0;
   assign pop      = rd_en && rd_valid;

   rxq_avail #(
      .DEPTH        (DEPTH),
      .THRESH_WORDS (THRESH_WORDS)
   ) u_avail (
      .clk       (clk),
      .rst_n     (rst_n),
      .store_fwd (cfg_store_fwd),
      .commit    (wr_commit),
      .pop_stat  (pop && rd_entry.tag == TAG_STAT),
      .vis_cnt   (vis_cnt),
      .avail     (rd_avail)
   );

   assign rd_data = rd_entry.word;
   assign rd_tag  = rd_entry.tag;
   assign rd_sof  = rd_entry.sof;
   assign rd_eof  = rd_entry.eof;
   assign rd_be   = rd_entry.be;
endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
   parameter int DEPTH = 512
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   cfg_store_fwd,
   input logic                   push,
   input logic [1:0]             push_tag,
   input logic [$clog2(DEPTH):0] used,
   input logic                   rd_valid,
   input logic                   rd_avail
);
   // R6
   sf_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_store_fwd && rd_valid |-> rd_avail);

   // R3
   ts_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push && push_tag == 2'd1 |=> push && push_tag == 2'd2);

   // R2
   stat_after_ts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push && push_tag == 2'd2 |=> push && push_tag == 2'd3);

   // R9
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      used <= ($clog2(DEPTH) + 1)'(DEPTH));

   // R10
   empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid && !push |=> !rd_valid);
endmodule

bind rx_frame_queue rxq_chk #(.DEPTH(DEPTH)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_store_fwd (cfg_store_fwd),
   .push          (wr_push),
   .push_tag      (wr_entry.tag),
   .used          (used_cnt),
   .rd_valid      (rd_valid),
   .rd_avail      (rd_avail)
);

// File: tb/rx_frame_queue_bench.sv
module rx_frame_queue_bench;
   localparam int DEPTH = 64;
   localparam int LIMIT = DEPTH - 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_store_fwd = 1'b0;
   logic        cfg_ts_en = 1'b0;
   logic        mac_valid = 1'b0;
   logic [31:0] mac_data = '0;
   logic        mac_sof = 1'b0;
   logic        mac_eof = 1'b0;
   logic [3:0]  mac_be = '0;
   logic        mac_stat_valid = 1'b0;
   logic [31:0] mac_stat = '0;
   logic        mac_ts_valid = 1'b0;
   logic [63:0] mac_ts = '0;
   logic        rd_en = 1'b0;
   logic        rd_valid;
   logic        rd_avail;
   logic [31:0] rd_data;
   logic [1:0]  rd_tag;
   logic        rd_sof;
   logic        rd_eof;
   logic [3:0]  rd_be;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   rx_frame_queue #(.DEPTH(DEPTH)) u_rx_frame_queue (
      .clk(clk), .rst_n(rst_n), .cfg_store_fwd(cfg_store_fwd), .cfg_ts_en(cfg_ts_en),
      .mac_valid(mac_valid), .mac_data(mac_data), .mac_sof(mac_sof), .mac_eof(mac_eof),
      .mac_be(mac_be), .mac_stat_valid(mac_stat_valid), .mac_stat(mac_stat),
      .mac_ts_valid(mac_ts_valid), .mac_ts(mac_ts), .rd_en(rd_en),
      .rd_valid(rd_valid), .rd_avail(rd_avail), .rd_data(rd_data), .rd_tag(rd_tag),
      .rd_sof(rd_sof), .rd_eof(rd_eof), .rd_be(rd_be)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic beat(input logic [31:0] d, input logic s, input logic e, input logic [3:0] be);
      mac_valid = 1'b1; mac_data = d; mac_sof = s; mac_eof = e; mac_be = be;
      @(negedge clk);
      mac_valid = 1'b0; mac_sof = 1'b0; mac_eof = 1'b0;
   endtask

   task automatic status(input logic [31:0] st, input logic tsv, input logic [63:0] ts);
      mac_stat_valid = 1'b1; mac_stat = st; mac_ts_valid = tsv; mac_ts = ts;
      @(negedge clk);
      mac_stat_valid = 1'b0; mac_ts_valid = 1'b0;
      idle(3);
   endtask

   task automatic send_data(input int n, input logic [31:0] base);
      for (int i = 0; i < n; i++)
         beat(base + 32'(i), i == 0, i == n - 1, (i == n - 1) ? 4'b0011 : 4'hF);
      idle(1);
   endtask

   task automatic send_frame(input int n, input logic [31:0] base, input logic [31:0] st,
                             input logic tsv, input logic [63:0] ts);
      send_data(n, base);
      status(st, tsv, ts);
   endtask

   task automatic expect_pop(input string req, input logic [1:0] tag, input logic s,
                             input logic e, input logic [3:0] be, input logic [31:0] w);
      chk(rd_valid && {rd_tag, rd_sof, rd_eof, rd_be, rd_data} == {tag, s, e, be, w}, req,
          64'({rd_valid, rd_tag, rd_sof, rd_eof, rd_be, rd_data}),
          64'({1'b1, tag, s, e, be, w}));
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic pop_frame(input string req, input int n, input logic [31:0] base,
                            input logic [31:0] st, input logic tsx, input logic [63:0] ts);
      for (int i = 0; i < n; i++)
         expect_pop(req, 2'd0, i == 0, i == n - 1, (i == n - 1) ? 4'b0011 : 4'hF, base + 32'(i));
      if (tsx) begin
         expect_pop(req, 2'd1, 1'b0, 1'b0, 4'h0, ts[31:0]);
         expect_pop(req, 2'd2, 1'b0, 1'b0, 4'h0, ts[63:32]);
      end
      expect_pop(req, 2'd3, 1'b0, 1'b0, 4'h0, st);
   endtask

   task automatic t_reset;
      chk(!rd_valid && !rd_avail, "R10 reset state", 64'({rd_valid, rd_avail}), 64'd0);
      rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
      send_frame(2, 32'hA000_0000, 32'h1, 1'b0, '0);
      pop_frame("R10 empty read ignored", 2, 32'hA000_0000, 32'h1, 1'b0, '0);
   endtask

   task automatic t_ct_short;
      cfg_store_fwd = 1'b0;
      send_data(3, 32'h1111_0000);
      chk(rd_valid, "R5 cut-through data visible", 64'(rd_valid), 64'd1);
      chk(!rd_avail, "R4 below threshold no frame", 64'(rd_avail), 64'd0);
      status(32'h0000_0042, 1'b0, '0);
      chk(rd_avail, "R4 complete frame", 64'(rd_avail), 64'd1);
      pop_frame("R1 R2 short frame", 3, 32'h1111_0000, 32'h42, 1'b0, '0);
      chk(!rd_valid && !rd_avail, "R4 drained", 64'({rd_valid, rd_avail}), 64'd0);
   endtask

   task automatic t_ct_thresh;
      cfg_store_fwd = 1'b0;
      for (int i = 0; i < 20; i++) begin
         beat(32'h2222_0000 + 32'(i), i == 0, i == 19, (i == 19) ? 4'b0011 : 4'hF);
         if (i == 14) chk(!rd_avail, "R4 15 words", 64'(rd_avail), 64'd0);
         if (i == 15) chk(rd_avail, "R4 16 words", 64'(rd_avail), 64'd1);
      end
      idle(1);
      status(32'h7, 1'b0, '0);
      pop_frame("R1 long frame", 20, 32'h2222_0000, 32'h7, 1'b0, '0);
   endtask

   task automatic t_ct_err;
      cfg_store_fwd = 1'b0;
      send_frame(2, 32'h3333_0000, 32'h0000_8005, 1'b0, '0);
      pop_frame("R5 errored frame forwarded", 2, 32'h3333_0000, 32'h0000_8005, 1'b0, '0);
   endtask

   task automatic t_ts_off;
      cfg_store_fwd = 1'b0; cfg_ts_en = 1'b0;
      send_frame(1, 32'h4444_0000, 32'h9, 1'b1, 64'h1234_5678_9ABC_DEF0);
      pop_frame("R3 timestamp disabled", 1, 32'h4444_0000, 32'h9, 1'b0, '0);
   endtask

   task automatic t_sf_drop;
      cfg_store_fwd = 1'b1; cfg_ts_en = 1'b1;
      send_frame(3, 32'h5555_0000, 32'h0000_8000, 1'b1, 64'h1);
      chk(!rd_valid && !rd_avail, "R7 bad frame gone", 64'({rd_valid, rd_avail}), 64'd0);
      send_data(2, 32'h6666_0000);
      chk(!rd_valid && !rd_avail, "R6 hidden before status", 64'({rd_valid, rd_avail}), 64'd0);
      status(32'h11, 1'b1, 64'hCAFE_F00D_0BAD_BEEF);
      chk(rd_avail, "R6 visible after status", 64'(rd_avail), 64'd1);
      pop_frame("R3 R7 good frame with timestamp", 2, 32'h6666_0000, 32'h11, 1'b1,
                64'hCAFE_F00D_0BAD_BEEF);
      cfg_ts_en = 1'b0;
   endtask

   task automatic t_sf_multi;
      cfg_store_fwd = 1'b1;
      send_frame(2, 32'h7777_0000, 32'h21, 1'b0, '0);
      send_frame(3, 32'h8888_0000, 32'h22, 1'b0, '0);
      pop_frame("R8 first frame", 2, 32'h7777_0000, 32'h21, 1'b0, '0);
      chk(rd_avail, "R8 second still pending", 64'(rd_avail), 64'd1);
      pop_frame("R8 second frame", 3, 32'h8888_0000, 32'h22, 1'b0, '0);
      chk(!rd_avail && !rd_valid, "R8 all read", 64'({rd_valid, rd_avail}), 64'd0);
   endtask

   task automatic t_overflow;
      cfg_store_fwd = 1'b0;
      send_data(70, 32'h9999_0000);
      status(32'h0, 1'b0, '0);
      for (int i = 0; i < LIMIT; i++)
         expect_pop("R9 kept beats", 2'd0, i == 0, 1'b0, 4'hF, 32'h9999_0000 + 32'(i));
      expect_pop("R9 overflow status bit", 2'd3, 1'b0, 1'b0, 4'h0, 32'h0000_4000);
      send_frame(1, 32'hAAAA_0000, 32'h3, 1'b0, '0);
      pop_frame("R9 flag cleared next frame", 1, 32'hAAAA_0000, 32'h3, 1'b0, '0);
   endtask

   task automatic t_sf_overflow;
      cfg_store_fwd = 1'b1;
      send_data(70, 32'hBBBB_0000);
      status(32'h0, 1'b0, '0);
      chk(!rd_valid && !rd_avail, "R7 overflowed frame dropped", 64'({rd_valid, rd_avail}), 64'd0);
      send_frame(2, 32'hCCCC_0000, 32'h5, 1'b0, '0);
      pop_frame("R7 frame after drop", 2, 32'hCCCC_0000, 32'h5, 1'b0, '0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      t_reset();
      t_ct_short();
      t_ct_thresh();
      t_ct_err();
      t_ts_off();
      t_sf_drop();
      t_sf_multi();
      t_overflow();
      t_sf_overflow();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule